// File: doc/BRIEF.md
# In-Order Retire Control Queue

This block does the slot bookkeeping of a reorder buffer. The dispatch side reserves one or more slots for an instruction and gets back a token, which is the queue position where the reservation begins. Execution later reports a token as done. On every cycle the block retires, oldest first, the run of finished instructions at the head of the queue. It returns their slots to the free pool and reports each retired instruction's index on its own retire lane.

The queue is circular with `DEPTH` slots, and `DEPTH` must be a power of two. A reservation takes between 1 and `DEPTH` slots. A count of zero takes one slot, and a count above the queue size is clamped to the queue size. The readiness flag answers whether the requested count, after that clamp, fits in the free slots. The `MAX_RETIRE` parameter bounds how many instructions may retire in one cycle, and 0 leaves retirement bounded only by the queue size. Operand values and architectural register commit are outside this block.

Top module: `rcq_retire_queue`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `free_o`=DEPTH, and no retire lane is valid.
- R2: An accepted reservation returns `rsv_token_o` equal to the current tail position. It then advances the tail by its effective slot count. A request of 0 micro-ops counts as 1 slot.
- R3: `rsv_ready_o` is 1 exactly when `free_o` is at least min(max(`rsv_uops_i`,1), DEPTH). A request above DEPTH therefore fits only in an empty queue.
- R4: A reservation requested while `rsv_ready_o`=0 changes no state, so `free_o` and the tail are unchanged.
- R5: A done notification on `exe_valid_i`/`exe_token_i` takes effect at the next clock edge. The token can retire, at the earliest, in the cycle after that edge.
- R6: Retirement is strictly in program order. A finished token does not retire while any older token is unfinished.
- R7: In one cycle, lane k (k=0 oldest) reports the k-th oldest retiring instruction, so the valid lanes form a contiguous group starting at lane 0. At most `MAX_RETIRE` instructions retire per cycle, and `MAX_RETIRE`=0 allows up to DEPTH.
- R8: At each edge `free_o` becomes the old value, minus the slots of an accepted reservation, plus the slots of all tokens retired in that cycle. With neither event it holds.
- R9: `full_o` is 1 exactly when `free_o`=0, and `empty_o` is 1 exactly when `free_o`=DEPTH.
- R10: A done notification naming a position that is not the start of a live token has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Reservation request |
| rsv_index_i | input | IDX_W | Instruction index stored with the token |
| rsv_uops_i | input | UOP_W | Requested micro-op (slot) count |
| rsv_ready_o | output | 1 | Request fits in the free slots (accepted when valid) |
| rsv_token_o | output | PTR_W | Token that the request receives (tail position) |
| exe_valid_i | input | 1 | Done notification |
| exe_token_i | input | PTR_W | Token that finished execution |
| ret_valid_o | output | LANES | Retire lane valid, lane 0 oldest |
| ret_index_o | output | LANES*IDX_W | Instruction index per retire lane |
| full_o | output | 1 | No free slots |
| empty_o | output | 1 | All slots free |
| free_o | output | CNT_W | Free slot count |

## Verification
On every cycle the assertions check the slot accounting. A blocked request never consumes slots, an accepted one always does, and the free count is stable when nothing happens. They also check that a full queue refuses every request, that the retire lanes form a contiguous group from lane 0, and that an empty queue retires nothing. Only the bench scenarios can show the values that need the token history. These are the token numbering, the clamp of oversized requests, the one-cycle delay from a done notification to retirement, and the wait behind an unfinished older token. They also cover the per-cycle retire limit against the unlimited setting, and done notifications aimed at positions inside a token's span.

// File: rtl/rcq_pkg.sv
package rcq_pkg;
  function automatic int calc_lanes(input int depth, input int limit);
    if (limit <= 0 || limit > depth) return depth;
    return limit;
  endfunction
endpackage

// File: rtl/rcq_alloc.sv
module rcq_alloc #(
  parameter int DEPTH = 16,
  parameter int UOP_W = 6,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             rsv_valid_i,
  input  logic [UOP_W-1:0] rsv_uops_i,
  input  logic [CNT_W-1:0] free_i,
  input  logic [PTR_W-1:0] tail_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] slots_o,
  output logic [PTR_W-1:0] tail_nxt_o
);
  logic [31:0] uops_w;
  assign uops_w = 32'(rsv_uops_i);

  always_comb begin
    if (uops_w == 32'd0)                slots_o = CNT_W'(1);
    else if (uops_w > 32'(DEPTH))       slots_o = CNT_W'(DEPTH);
    else                                slots_o = CNT_W'(uops_w);
  end

  assign ready_o    = free_i >= slots_o;
  assign accept_o   = rsv_valid_i && ready_o;
  assign tail_nxt_o = tail_i + slots_o[PTR_W-1:0];  // DEPTH slots wrap to tail
endmodule

// File: rtl/rcq_token_table.sv
module rcq_token_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [PTR_W-1:0]            wr_ptr_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [CNT_W-1:0]            wr_slots_i,
  input  logic                        exe_valid_i,
  input  logic [PTR_W-1:0]            exe_ptr_i,
  input  logic [DEPTH-1:0]            clr_mask_i,
  output logic [DEPTH-1:0]            live_o,
  output logic [DEPTH-1:0]            done_o,
  output logic [DEPTH-1:0][IDX_W-1:0] idx_o,
  output logic [DEPTH-1:0][CNT_W-1:0] slots_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_o <= '0;
      done_o <= '0;
    end else begin
      if (exe_valid_i && live_o[exe_ptr_i]) done_o[exe_ptr_i] <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (clr_mask_i[i]) begin
          live_o[i] <= 1'b0;
          done_o[i] <= 1'b0;
        end
      end
      // tail never overlaps a live or retiring start position
      if (wr_en_i) begin
        live_o[wr_ptr_i] <= 1'b1;
        done_o[wr_ptr_i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      idx_o[wr_ptr_i]   <= wr_idx_i;
      slots_o[wr_ptr_i] <= wr_slots_i;
    end
  end
endmodule

// File: rtl/rcq_retire_scan.sv
module rcq_retire_scan #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 16,
  parameter int LANES = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic [PTR_W-1:0]            head_i,
  input  logic [CNT_W-1:0]            used_i,
  input  logic [DEPTH-1:0]            live_i,
  input  logic [DEPTH-1:0]            done_i,
  input  logic [DEPTH-1:0][IDX_W-1:0] idx_i,
  input  logic [DEPTH-1:0][CNT_W-1:0] slots_i,
  output logic [LANES-1:0]            ret_valid_o,
  output logic [LANES-1:0][IDX_W-1:0] ret_index_o,
  output logic [DEPTH-1:0]            clr_mask_o,
  output logic [CNT_W-1:0]            freed_o
);
  logic [LANES-1:0][PTR_W-1:0] lane_ptr;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PTR_W-1:0] ptr;
    logic [CNT_W-1:0] cum;
    logic             go;
    logic             hit;
    logic [PTR_W-1:0] ptr_nxt;
    logic [CNT_W-1:0] cum_nxt;

    if (k == 0) begin : g_first
      assign ptr = head_i;
      assign cum = '0;
      assign go  = 1'b1;
    end else begin : g_next
      assign ptr = g_lane[k-1].ptr_nxt;
      assign cum = g_lane[k-1].cum_nxt;
      assign go  = g_lane[k-1].hit;
    end

    // cum bound stops the walk once every occupied slot is consumed
    assign hit     = go && (cum < used_i) && live_i[ptr] && done_i[ptr];
    assign ptr_nxt = ptr + slots_i[ptr][PTR_W-1:0];
    assign cum_nxt = hit ? cum + slots_i[ptr] : cum;

    assign ret_valid_o[k] = hit;
    assign ret_index_o[k] = idx_i[ptr];
    assign lane_ptr[k]    = ptr;
  end

  assign freed_o = g_lane[LANES-1].cum_nxt;

  always_comb begin
    clr_mask_o = '0;
    for (int k = 0; k < LANES; k++)
      if (ret_valid_o[k]) clr_mask_o[lane_ptr[k]] = 1'b1;
  end
endmodule

// File: rtl/rcq_retire_queue.sv
module rcq_retire_queue #(
  parameter int DEPTH      = 16,
  parameter int IDX_W      = 16,
  parameter int UOP_W      = 6,
  parameter int MAX_RETIRE = 0,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int LANES     = rcq_pkg::calc_lanes(DEPTH, MAX_RETIRE)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rsv_valid_i,
  input  logic [IDX_W-1:0]            rsv_index_i,
  input  logic [UOP_W-1:0]            rsv_uops_i,
  output logic                        rsv_ready_o,
  output logic [PTR_W-1:0]            rsv_token_o,
  input  logic                        exe_valid_i,
  input  logic [PTR_W-1:0]            exe_token_i,
  output logic [LANES-1:0]            ret_valid_o,
  output logic [LANES-1:0][IDX_W-1:0] ret_index_o,
  output logic                        full_o,
  output logic                        empty_o,
  output logic [CNT_W-1:0]            free_o
);
  logic [PTR_W-1:0]            head_q, tail_q, tail_nxt;
  logic [CNT_W-1:0]            free_q, used, rsv_slots, freed;
  logic                        accept;
  logic [DEPTH-1:0]            live, done, clr_mask;
  logic [DEPTH-1:0][IDX_W-1:0] tbl_idx;
  logic [DEPTH-1:0][CNT_W-1:0] tbl_slots;

  assign used = CNT_W'(DEPTH) - free_q;

  rcq_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_alloc (
    .rsv_valid_i(rsv_valid_i),
    .rsv_uops_i (rsv_uops_i),
    .free_i     (free_q),
    .tail_i     (tail_q),
    .ready_o    (rsv_ready_o),
    .accept_o   (accept),
    .slots_o    (rsv_slots),
    .tail_nxt_o (tail_nxt)
  );

  rcq_token_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (accept),
    .wr_ptr_i   (tail_q),
    .wr_idx_i   (rsv_index_i),
    .wr_slots_i (rsv_slots),
    .exe_valid_i(exe_valid_i),
    .exe_ptr_i  (exe_token_i),
    .clr_mask_i (clr_mask),
    .live_o     (live),
    .done_o     (done),
    .idx_o      (tbl_idx),
    .slots_o    (tbl_slots)
  );

  rcq_retire_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LANES(LANES), .PTR_W(PTR_W),
                    .CNT_W(CNT_W)) u_scan (
    .head_i     (head_q),
    .used_i     (used),
    .live_i     (live),
    .done_i     (done),
    .idx_i      (tbl_idx),
    .slots_i    (tbl_slots),
    .ret_valid_o(ret_valid_o),
    .ret_index_o(ret_index_o),
    .clr_mask_o (clr_mask),
    .freed_o    (freed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      head_q <= head_q + freed[PTR_W-1:0];
      if (accept) tail_q <= tail_nxt;
      free_q <= free_q - (accept ? rsv_slots : '0) + freed;
    end
  end

  assign rsv_token_o = tail_q;
  assign free_o      = free_q;
  assign full_o      = (free_q == '0);
  assign empty_o     = (free_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rcq_retire_queue_chk.sv
module rcq_retire_queue_chk #(
  parameter int DEPTH = 16,
  parameter int LANES = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rsv_valid_i,
  input logic             rsv_ready_o,
  input logic [LANES-1:0] ret_valid_o,
  input logic             full_o,
  input logic             empty_o,
  input logic [CNT_W-1:0] free_o
);
  AST_BLOCKED_NO_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_valid_i && !rsv_ready_o |=> free_o >= $past(free_o)); // R4
  AST_RESERVE_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_valid_i && rsv_ready_o && ret_valid_o == '0 |=> free_o < $past(free_o)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsv_valid_i && rsv_ready_o) && ret_valid_o == '0 |=> $stable(free_o)); // R8
  AST_FREE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o <= CNT_W'(DEPTH)); // R8
  AST_FULL_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !rsv_ready_o); // R9
  AST_LANES_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_valid_o + LANES'(1)) & ret_valid_o) == '0); // R7
  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> ret_valid_o == '0); // R6
endmodule

bind rcq_retire_queue rcq_retire_queue_chk #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rsv_valid_i(rsv_valid_i),
  .rsv_ready_o(rsv_ready_o),
  .ret_valid_o(ret_valid_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .free_o     (free_o)
);

// File: tb/rcq_ref.sv
module rcq_ref #(
  parameter int DEPTH = 8,
  parameter int LIMIT = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rsv_valid,
  input logic [7:0] rsv_index,
  input logic [4:0] rsv_uops,
  input logic       exe_valid,
  input logic [2:0] exe_token
);
  int q_pos[$];
  int q_idx[$];
  int q_n[$];
  bit q_ex[$];
  int tail;
  int free_cnt;

  int exp_ready, exp_token, exp_full, exp_empty, exp_free, exp_ret_n, exp_slots;
  int exp_ret_idx[DEPTH];

  function automatic void eval();
    int u;
    u = int'(rsv_uops);
    exp_slots = (u == 0) ? 1 : ((u > DEPTH) ? DEPTH : u);
    exp_ready = (free_cnt >= exp_slots) ? 1 : 0;
    exp_token = tail;
    exp_free  = free_cnt;
    exp_full  = (free_cnt == 0) ? 1 : 0;
    exp_empty = (free_cnt == DEPTH) ? 1 : 0;
    exp_ret_n = 0;
    while (exp_ret_n < q_pos.size() && q_ex[exp_ret_n] &&
           (LIMIT == 0 || exp_ret_n < LIMIT)) begin
      exp_ret_idx[exp_ret_n] = q_idx[exp_ret_n];
      exp_ret_n++;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_pos.delete(); q_idx.delete(); q_n.delete(); q_ex.delete();
      tail = 0;
      free_cnt = DEPTH;
    end else begin
      eval();
      for (int i = 0; i < q_pos.size(); i++)
        if (exe_valid && q_pos[i] == int'(exe_token)) q_ex[i] = 1'b1;
      for (int i = 0; i < exp_ret_n; i++) begin
        free_cnt += q_n[0];
        void'(q_pos.pop_front()); void'(q_idx.pop_front());
        void'(q_n.pop_front());   void'(q_ex.pop_front());
      end
      if (rsv_valid && exp_ready == 1) begin
        q_pos.push_back(tail); q_idx.push_back(int'(rsv_index));
        q_n.push_back(exp_slots); q_ex.push_back(1'b0);
        tail = (tail + exp_slots) % DEPTH;
        free_cnt -= exp_slots;
      end
    end
  end
endmodule

// File: tb/rcq_retire_queue_test.sv
`timescale 1ns/1ps
module rcq_retire_queue_test;
  localparam int DEPTH = 8;
  localparam int IDX_W = 8;
  localparam int UOP_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsv_valid = 1'b0;
  logic [IDX_W-1:0] rsv_index = '0;
  logic [UOP_W-1:0] rsv_uops = '0;
  logic exe_valid = 1'b0;
  logic [2:0] exe_token = '0;

  logic a_ready, a_full, a_empty;
  logic [2:0] a_token;
  logic [7:0] a_rv;
  logic [7:0][IDX_W-1:0] a_ri;
  logic [3:0] a_free;
  logic b_ready, b_full, b_empty;
  logic [2:0] b_token;
  logic [1:0] b_rv;
  logic [1:0][IDX_W-1:0] b_ri;
  logic [3:0] b_free;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  rcq_retire_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W), .UOP_W(UOP_W), .MAX_RETIRE(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rsv_valid_i(rsv_valid), .rsv_index_i(rsv_index),
    .rsv_uops_i(rsv_uops), .rsv_ready_o(a_ready), .rsv_token_o(a_token),
    .exe_valid_i(exe_valid), .exe_token_i(exe_token), .ret_valid_o(a_rv),
    .ret_index_o(a_ri), .full_o(a_full), .empty_o(a_empty), .free_o(a_free));

  rcq_retire_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W), .UOP_W(UOP_W), .MAX_RETIRE(2)) uut_lim (
    .clk_i(clk), .rst_ni(rst_n), .rsv_valid_i(rsv_valid), .rsv_index_i(rsv_index),
    .rsv_uops_i(rsv_uops), .rsv_ready_o(b_ready), .rsv_token_o(b_token),
    .exe_valid_i(exe_valid), .exe_token_i(exe_token), .ret_valid_o(b_rv),
    .ret_index_o(b_ri), .full_o(b_full), .empty_o(b_empty), .free_o(b_free));

  rcq_ref #(.DEPTH(DEPTH), .LIMIT(0)) ref_a (.clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid),
    .rsv_index(rsv_index), .rsv_uops(rsv_uops), .exe_valid(exe_valid), .exe_token(exe_token));
  rcq_ref #(.DEPTH(DEPTH), .LIMIT(2)) ref_b (.clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid),
    .rsv_index(rsv_index), .rsv_uops(rsv_uops), .exe_valid(exe_valid), .exe_token(exe_token));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    ref_a.eval();
    ref_b.eval();
    chk("R3", "ready", int'(a_ready), ref_a.exp_ready);
    chk("R2", "token", int'(a_token), ref_a.exp_token);
    chk("R8", "free", int'(a_free), ref_a.exp_free);
    chk("R9", "full", int'(a_full), ref_a.exp_full);
    chk("R9", "empty", int'(a_empty), ref_a.exp_empty);
    chk("R7", "retire count", $countones(a_rv), ref_a.exp_ret_n);
    for (int k = 0; k < 8; k++)
      if (k < ref_a.exp_ret_n) chk("R6", "retire index", int'(a_ri[k]), ref_a.exp_ret_idx[k]);
    chk("R3", "lim ready", int'(b_ready), ref_b.exp_ready);
    chk("R8", "lim free", int'(b_free), ref_b.exp_free);
    chk("R7", "lim retire count", $countones(b_rv), ref_b.exp_ret_n);
    for (int k = 0; k < 2; k++)
      if (k < ref_b.exp_ret_n) chk("R6", "lim retire index", int'(b_ri[k]), ref_b.exp_ret_idx[k]);
  endtask

  // drive at negedge, compare pre-edge outputs shortly after
  task automatic step(input bit rv, input int idx, input int uops, input bit ev, input int tok);
    @(negedge clk);
    rsv_valid = rv;
    rsv_index = IDX_W'(idx);
    rsv_uops  = UOP_W'(uops);
    exe_valid = ev;
    exe_token = 3'(tok);
    #0.5;
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 0, 0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    idle();
    chk("R1", "reset empty", int'(a_empty), 1);
    chk("R1", "reset full", int'(a_full), 0);
    chk("R1", "reset free", int'(a_free), DEPTH);
    chk("R1", "reset retire", int'(a_rv), 0);

    step(1'b1, 1, 2, 1'b0, 0);
    chk("R2", "first token", int'(a_token), 0);
    step(1'b1, 2, 0, 1'b0, 0);
    chk("R2", "zero-uop token", int'(a_token), 2);
    step(1'b1, 3, 3, 1'b0, 0);
    chk("R2", "third token", int'(a_token), 3);
    idle();
    chk("R2", "free after three", int'(a_free), 2);

    step(1'b0, 0, 0, 1'b1, 3);
    idle();
    chk("R6", "younger waits", int'(a_rv), 0);

    step(1'b1, 9, 20, 1'b0, 0);
    chk("R3", "oversize refused", int'(a_ready), 0);
    idle();
    chk("R4", "refused no change", int'(a_free), 2);
    chk("R4", "refused tail", int'(a_token), 6);

    step(1'b1, 4, 2, 1'b0, 0);
    chk("R2", "fourth token", int'(a_token), 6);
    idle();
    chk("R9", "full flag", int'(a_full), 1);

    step(1'b0, 0, 0, 1'b1, 1);
    idle();
    chk("R10", "mid-span notify", int'(a_rv), 0);
    chk("R10", "mid-span free", int'(a_free), 0);

    step(1'b0, 0, 0, 1'b1, 0);
    chk("R5", "same cycle no retire", int'(a_rv), 0);
    idle();
    chk("R5", "retire next cycle", int'(a_rv), 1);
    chk("R5", "retire index", int'(a_ri[0]), 1);

    step(1'b0, 0, 0, 1'b1, 6);
    step(1'b0, 0, 0, 1'b1, 2);
    idle();
    chk("R7", "unlimited burst", $countones(a_rv), 3);
    chk("R7", "burst order", int'(a_ri[2]), 4);
    chk("R7", "limited burst", $countones(b_rv), 2);
    idle();
    chk("R9", "empty after burst", int'(a_empty), 1);
    chk("R7", "limited tail", int'(b_ri[0]), 4);
    idle();

    step(1'b1, 7, 20, 1'b0, 0);
    chk("R3", "oversize on empty", int'(a_ready), 1);
    idle();
    chk("R3", "oversize takes all", int'(a_free), 0);
    step(1'b0, 0, 0, 1'b1, int'(a_token));
    idle();
    idle();
    chk("R8", "freed all", int'(a_free), DEPTH);

    for (int c = 0; c < 600; c++) begin
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 11)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 7)));
    end

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule